// File: doc/BRIEF.md
# Transmit 64b/66b Gearbox with Internal Sequence Counter

This block takes 64-bit payload blocks, each paired with a 2-bit sync header, and packs the resulting 66-bit blocks into an unbroken stream of output words. The input and output words have the same width, 32 or 16 bits, chosen by the parameter `W`. A block arrives as two input words (32-bit) or four input words (16-bit). The header is sampled only on the first word of each block. A leftover-bit register carries the bits that did not fit into the current output word over to the next one.

Every 66-bit block carries two more bits than its payload. After sixteen blocks the extra header bits add up to a full 32 bits, so the user side must pause once per period while the output keeps running. A sequence counter inside the block schedules this pause. It announces the pause on `in_ready` one cycle early, and one more word is taken on the cycle `in_ready` falls. The input side uses a valid/ready handshake with these back-pressure rules. `in_start` acts as the stream-valid and stays high once transmission has begun. A word is taken on every cycle where `in_ready` is high, and also on the single cycle where `in_ready` has just fallen. Words presented on the other low cycles are dropped. The output side has no back-pressure: once `out_valid` rises, a word leaves on every cycle.

Top module: `gbx_tx`

## Requirements
- R1: While `in_start` has stayed low since reset, `out_valid` is 0, `in_ready` is 1 and the presented header and data are not taken.
- R2: `in_ready` is 0 while `rst` is high. It is 1 on the first cycle after the cycle in which `rst` is sampled low.
- R3: The header and data present on the first cycle where `in_start` is high (with `in_ready` high) form the first word of the first transmitted block.
- R4: Once running, `in_ready` is low for runs of exactly 2 cycles (W=32) or 3 cycles (W=16). One such run occurs per period of 33 cycles (W=32) or 66 cycles (W=16).
- R5: The word presented on the cycle where `in_ready` falls is taken.
- R6: Words presented on the other cycles where `in_ready` is low are ignored. Acceptance resumes on the cycle where `in_ready` is high again.
- R7: From the cycle after the start cycle, `out_valid` is 1 on every cycle, including pause cycles.
- R8: Bit order on the wire runs as follows: header bit 0, header bit 1, then payload bit 0 upward. The header is sampled from the first word of each block. Each output word carries the earliest bit in bit 0.
- R9: The concatenated output bits equal the concatenation of the 66-bit blocks built from the taken words, for both W=32 and W=16.
- R10: Asserting `rst` mid-stream clears `out_valid` and `in_ready`. The block returns to the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User clock, single domain |
| rst | input | 1 | Synchronous reset, active high |
| in_start | input | 1 | Stream-valid: begins transmission on its first high cycle |
| in_header | input | 2 | Sync header, sampled on the first word of each block |
| in_data | input | W | Payload word |
| in_ready | output | 1 | Drops one cycle before the pause; the falling cycle still takes a word |
| out_data | output | W | Packed output word, earliest bit in bit 0 |
| out_valid | output | 1 | High on every cycle once transmission has started |

## Verification
The bench drives fresh data and headers on every cycle, including idle cycles and pause cycles. A design that took a word during idle or on the second pause cycle would therefore shift the whole stream and fail the block comparison. A design that dropped the word on the cycle `in_ready` falls would fail the same way. It would also fail the taken-word counts for run lengths that end before, inside or after a pause. Both widths run side by side, so a counter period or pause length that is wrong for 16-bit words is caught even where the 32-bit instance is correct. Resets land mid-stream and inside a pause, so a leftover-bit register or a counter that survives reset corrupts the first block after restart.

// File: rtl/gbx_pkg.sv
`timescale 1ns/1ps
package gbx_pkg;
  localparam int PAY_BITS       = 64;
  localparam int HDR_BITS       = 2;
  localparam int BLK_PER_PERIOD = 16;

  // input words that make up one payload block
  function automatic int words_per_blk(input int w);
    return PAY_BITS / w;
  endfunction

  // cycles per period in which the user side is held off
  function automatic int pause_words(input int w);
    return (BLK_PER_PERIOD * HDR_BITS) / w;
  endfunction
endpackage

// File: rtl/gbx_seq.sv
`timescale 1ns/1ps
module gbx_seq
  import gbx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready,
  output logic take,
  output logic first,
  output logic go
);
  localparam int WPB   = words_per_blk(W);
  localparam int PAUSE = pause_words(W);
  localparam int ACC   = BLK_PER_PERIOD * WPB;
  localparam int PER   = ACC + PAUSE;
  localparam int CW    = $clog2(PER);
  localparam int IW    = (WPB > 1) ? $clog2(WPB) : 1;
  localparam logic [CW-1:0] LAST     = CW'(PER - 1);
  localparam logic [CW-1:0] TAKE_LIM = CW'(ACC);
  localparam logic [CW-1:0] RDY_LIM  = CW'(ACC - 1);

  logic [CW-1:0] seq_q;
  logic          run_q;
  logic          en_q;

  // the counter advances from the start cycle onward
  assign go    = en_q & (run_q | start);
  assign take  = go & (seq_q < TAKE_LIM);
  // ready leads the hold-off by one cycle
  assign ready = en_q & (seq_q < RDY_LIM);
  assign first = (seq_q[IW-1:0] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q <= '0;
      run_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      en_q <= 1'b1;
      if (go) begin
        run_q <= 1'b1;
        seq_q <= (seq_q == LAST) ? '0 : seq_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gbx_pack.sv
`timescale 1ns/1ps
module gbx_pack
  import gbx_pkg::*;
#(
  parameter int W     = 32,
  parameter int RES_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                take,
  input  logic                first,
  input  logic                emit,
  input  logic [HDR_BITS-1:0] hdr,
  input  logic [W-1:0]        data,
  output logic [W-1:0]        word,
  output logic                valid
);
  localparam int NW   = W + HDR_BITS;
  localparam int WW   = RES_W + NW;
  localparam int CNTW = $clog2(RES_W + 1);
  localparam int SW   = CNTW + 1;

  logic [RES_W-1:0] res_q;
  logic [CNTW-1:0]  cnt_q;
  logic [NW-1:0]    nb;
  logic [WW-1:0]    wide;
  logic [SW-1:0]    len;
  logic [SW-1:0]    tot;

  always_comb begin
    // header goes out ahead of the payload
    nb   = first ? {data, hdr} : {{HDR_BITS{1'b0}}, data};
    len  = take ? (first ? SW'(NW) : SW'(W)) : '0;
    wide = {{NW{1'b0}}, res_q};
    if (take) wide = wide | ({{RES_W{1'b0}}, nb} << cnt_q);
    tot  = SW'(cnt_q) + len;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q <= '0;
      cnt_q <= '0;
      word  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= emit;
      if (emit) begin
        word  <= wide[W-1:0];
        res_q <= wide[W +: RES_W];
        cnt_q <= CNTW'(tot - SW'(W));
      end else begin
        word <= '0;
      end
    end
  end
endmodule

// File: rtl/gbx_tx.sv
`timescale 1ns/1ps
module gbx_tx
  import gbx_pkg::*;
#(
  parameter int W     = 32,
  parameter int RES_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_start,
  input  logic [HDR_BITS-1:0] in_header,
  input  logic [W-1:0]        in_data,
  output logic                in_ready,
  output logic [W-1:0]        out_data,
  output logic                out_valid
);
  logic take_w;
  logic first_w;
  logic go_w;

  gbx_seq #(.W(W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (in_start),
    .ready (in_ready),
    .take  (take_w),
    .first (first_w),
    .go    (go_w)
  );

  gbx_pack #(.W(W), .RES_W(RES_W)) u_pack (
    .clk   (clk),
    .rst   (rst),
    .take  (take_w),
    .first (first_w),
    .emit  (go_w),
    .hdr   (in_header),
    .data  (in_data),
    .word  (out_data),
    .valid (out_valid)
  );
endmodule

// File: rtl/gbx_tx_chk.sv
`timescale 1ns/1ps
module gbx_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_start,
  input logic in_ready,
  input logic out_valid,
  input logic take
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_start && !out_valid) |=> !out_valid);

  // R2
  ready_up_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> in_ready);

  // R4
  ready_dwell_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(in_ready) && out_valid) |=> !in_ready);

  // R5
  last_take_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ready) |-> take);

  // R6
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !$fell(in_ready)) |-> !take);

  // R7
  stream_on_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> out_valid);
endmodule

bind gbx_tx gbx_tx_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_start  (in_start),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .take      (take_w)
);

// File: tb/gbx_tx_bench.sv
`timescale 1ns/1ps
module gbx_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st  = 1'b0;
  logic [1:0]  h0 = '0, h1 = '0;
  logic [31:0] d0 = '0;
  logic [15:0] d1 = '0;
  wire         r0, r1, v0, v1;
  wire  [31:0] o0;
  wire  [15:0] o1;

  always #2 clk = ~clk;

  gbx_tx #(.W(32)) u_gbx_tx (
    .clk(clk), .rst(rst), .in_start(st), .in_header(h0), .in_data(d0),
    .in_ready(r0), .out_data(o0), .out_valid(v0));

  gbx_tx #(.W(16)) u_gbx_tx_n (
    .clk(clk), .rst(rst), .in_start(st), .in_header(h1), .in_data(d1),
    .in_ready(r1), .out_data(o1), .out_valid(v1));

  // idle cycles, run cycles, words taken at W=32, words taken at W=16
  localparam int SCN [5][4] = '{
    '{2, 10, 10, 10}, '{0, 33, 32, 33}, '{5, 40, 39, 40},
    '{1, 70, 68, 68}, '{0, 140, 136, 136}};

  int checks = 0, errors = 0;
  bit eb [2][8192];
  bit gb [2][8192];
  int ew [2], er [2], gw [2], gr [2], wi [2], acc_n [2], lr [2], bc [2];
  logic rp [2];
  logic st_q = 1'b0;
  int unsigned tick = 0;

  function automatic int wof(input int i);
    return (i == 0) ? 32 : 16;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [65:0] act, input logic [65:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_blocks();
    logic [65:0] a, e;
    for (int i = 0; i < 2; i++) begin
      while ((ew[i] - er[i] >= 66) && (gw[i] - gr[i] >= 66)) begin
        for (int b = 0; b < 66; b++) begin
          a[b] = gb[i][gr[i] + b];
          e[b] = eb[i][er[i] + b];
        end
        gr[i] += 66;
        er[i] += 66;
        chk(a == e, (bc[i] == 0) ? "R3 first block" : "R9 R8 block", a, e);
        bc[i]++;
      end
    end
  endtask

  task automatic cyc(input logic s);
    logic        ov, rdy, acc;
    logic [31:0] od, dd;
    logic [1:0]  hh;
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      ov = (i == 0) ? v0 : v1;
      od = (i == 0) ? o0 : {16'b0, o1};
      chk(ov === st_q, st_q ? "R7 valid while running" : "R1 idle valid", 66'(ov), 66'(st_q));
      if (ov) for (int b = 0; b < wof(i); b++) begin
        gb[i][gw[i]] = od[b];
        gw[i]++;
      end
    end
    tick++;
    st = s;
    d0 = tick * 32'h9E3779B1 + 32'h01234567;
    d1 = 16'((tick * 32'h85EBCA6B) ^ 32'h0000ABCD);
    h0 = 2'(tick * 3 + 1);
    h1 = 2'(tick * 5 + 2);
    for (int i = 0; i < 2; i++) begin
      rdy = (i == 0) ? r0 : r1;
      dd  = (i == 0) ? d0 : {16'b0, d1};
      hh  = (i == 0) ? h0 : h1;
      acc = s && (rdy || rp[i]);
      if (acc) begin
        if (wi[i] == 0) begin
          eb[i][ew[i]] = hh[0];
          eb[i][ew[i] + 1] = hh[1];
          ew[i] += 2;
        end
        for (int b = 0; b < wof(i); b++) begin
          eb[i][ew[i]] = dd[b];
          ew[i]++;
        end
        wi[i] = (wi[i] + 1) % (64 / wof(i));
        acc_n[i]++;
      end
      if (s) begin
        if (!rdy) lr[i]++;
        else if (lr[i] > 0) begin
          chk(lr[i] == (32 / wof(i)) + 1, "R4 ready-low run", 66'(lr[i]), 66'((32 / wof(i)) + 1));
          lr[i] = 0;
        end
      end
      rp[i] = rdy;
    end
    st_q = s;
    cmp_blocks();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    st  = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk({r0, r1, v0, v1} == 4'b0, "R10 R2 reset state", 66'({r0, r1, v0, v1}), 66'(0));
    end
    for (int i = 0; i < 2; i++) begin
      ew[i] = 0; er[i] = 0; gw[i] = 0; gr[i] = 0;
      wi[i] = 0; acc_n[i] = 0; lr[i] = 0; bc[i] = 0;
    end
    st_q = 1'b0;
    rst  = 1'b0;
    @(negedge clk);
    chk(r0 && r1, "R2 ready after reset", 66'({r0, r1}), 66'(3));
    rp[0] = r0;
    rp[1] = r1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      cyc(1'b0);
      chk(r0 && r1, "R1 ready while idle", 66'({r0, r1}), 66'(3));
    end
  endtask

  initial begin
    for (int k = 0; k < 5; k++) begin
      do_reset();
      idle(SCN[k][0]);
      repeat (SCN[k][1]) cyc(1'b1);
      chk(acc_n[0] == SCN[k][2], "R5 R6 words taken W=32", 66'(acc_n[0]), 66'(SCN[k][2]));
      chk(acc_n[1] == SCN[k][3], "R5 R6 words taken W=16", 66'(acc_n[1]), 66'(SCN[k][3]));
      chk(bc[0] > 0, "R9 blocks seen W=32", 66'(bc[0]), 66'(1));
    end
    // reset landing inside a pause, then a long idle before restart
    do_reset();
    repeat (32) cyc(1'b1);
    chk(r0 == 1'b0, "R4 ready low inside pause", 66'(r0), 66'(0));
    do_reset();
    idle(40);
    chk(bc[0] == 0 && bc[1] == 0, "R10 R1 nothing sent while idle", 66'(bc[0] + bc[1]), 66'(0));
    repeat (50) cyc(1'b1);
    chk(acc_n[0] == 49, "R5 R6 words taken after restart W=32", 66'(acc_n[0]), 66'(49));
    chk(acc_n[1] == 50, "R5 R6 words taken after restart W=16", 66'(acc_n[1]), 66'(50));
    chk(bc[1] > 0, "R9 blocks seen W=16", 66'(bc[1]), 66'(1));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule